// File: doc/BRIEF.md
# IO rail deep-power-down controller

This block moves a single IO rail into or out of deep power down. Up to 64 rails are spread over two banks of 32 bits. Each bank has its own request word and its own status vector. The top two bit positions of every bank are reserved, so each bank offers 30 rails.

A command gives a rail number, a direction and a start strobe. The controller then runs a fixed sequence:
1. It raises the pad sampling enable.
2. It loads a settle timer with a minimum wait of 200 ns, expressed in clock cycles.
3. It writes a request word to the selected bank. The word holds the two-bit action in its top bits and the rail's one-hot bit below.
4. It watches that rail's status bit until the bit shows the requested state, or until a cycle budget runs out.

At the end it drops the sampling enable and pulses either `done` or `err`. A rail number that names no usable rail is refused at once, with no activity on the request side. Only one command runs at a time.

Top module: `rail_dpd_ctrl`

## Requirements
- R1: Rail ids 0..31 select bank 0 and ids 32..63 select bank 1 (`req_bank`). Within the bank, the rail's bit is at position id mod 32 of `req_word`.
- R2: An id above 63, or an id whose position inside its bank is 30 or 31, is refused. One cycle after the start, `err`=1 and `err_timeout`=0. `busy`, `sample_en` and `req_wr` stay 0 throughout.
- R3: In the request word, bits 31:30 carry the action: 01 to leave deep power down (`cmd_off`=0) and 10 to enter it (`cmd_off`=1). Code 00 is idle and is never written. Bits 29:0 hold only the selected rail's bit.
- R4: Leaving completes when the selected rail's status bit reads 0. Entering completes when it reads 1. Status bits of all other rails have no effect. Status is compared from the fourth clock edge after the accepted start onward, so `done` appears no earlier than four edges after the start.
- R5: Order after an accepted start: `sample_en` rises at edge 1. `dpd_timer` is loaded at edge 2. `req_wr` is high for exactly the one cycle after edge 3, and `sample_en` is high during it.
- R6: `sample_en` falls on the same edge that raises `done` or `err`, whether the wait passed or timed out.
- R7: `dpd_timer` equals ceil(200 / p), where p is the clock period rounded up to whole ns. With a 6 ns clock it is 34.
- R8: If the status has not matched after `TIMEOUT_CYCLES` compare edges, `err` pulses with `err_timeout`=1. A match on the last compare edge still counts as success.
- R9: `busy` is high from the edge after an accepted start until the edge that raises `done` or `err`. A start seen while busy is ignored.
- R10: `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start strobe for a command |
| cmd_rail | input | ID_W (7) | Rail id of the command |
| cmd_off | input | 1 | 1: enter deep power down, 0: leave it |
| busy | output | 1 | A command is in flight |
| done | output | 1 | Pulse: status matched |
| err | output | 1 | Pulse: command refused or timed out |
| err_timeout | output | 1 | Qualifies `err`: 1 for timeout, 0 for refused id |
| sample_en | output | 1 | Pad input sampling enable |
| dpd_timer | output | TIMER_W (16) | Settle time in clock cycles |
| req_wr | output | 1 | Write strobe for the request word |
| req_bank | output | SEL_W (1) | Bank the request word goes to |
| req_word | output | BANK_W (32) | Action code and rail mask |
| rail_status | input | NUM_BANKS*BANK_W (64) | Per-rail state, 1 = in deep power down, bank b at bits b*32+ |

## Verification
The assertions assume `rail_status` is synchronous to `clk` and free of metastability. They also assume the command fields are stable on the edge where `cmd_start` is seen. The stimulus honours this: it changes the status vector and all command inputs only at the falling edge. A rail model flips the commanded bit a chosen number of cycles after the request strobe. Unrelated rails, including the reserved positions, are toggled on every cycle. Start strobes aimed at other rails are injected while a command runs, to probe that nothing interferes with the latched command.

// File: rtl/rail_dpd_pkg.sv
`timescale 1ns/1ps
package rail_dpd_pkg;

   // action codes placed in the top two bits of a request word
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'b00,
      ACT_LEAVE = 2'b01,
      ACT_ENTER = 2'b10
   } dpd_act_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_TIME,
      ST_REQ,
      ST_POLL
   } seq_st_e;

   // clock period rounded up to whole ns, never zero
   function automatic int unsigned period_ns(input int unsigned period_ps);
      int unsigned p;
      p = (period_ps + 999) / 1000;
      if (p == 0) p = 1;
      return p;
   endfunction

   // cycles needed to cover min_ns with a clock of period_ps
   function automatic int unsigned settle_cycles(input int unsigned period_ps,
                                                 input int unsigned min_ns);
      int unsigned p;
      p = period_ns(period_ps);
      return (min_ns + p - 1) / p;
   endfunction

endpackage

// File: rtl/rail_dpd_decode.sv
`timescale 1ns/1ps
module rail_dpd_decode #(
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = 32,
   parameter int ID_W      = 7,
   parameter int RSVD_BITS = 2,
   localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int BIT_W    = $clog2(BANK_W)
) (
   input  logic [ID_W-1:0]  id,
   output logic [SEL_W-1:0] bank,
   output logic [BIT_W-1:0] bitpos,
   output logic             valid
);
   localparam int TOTAL     = NUM_BANKS * BANK_W;
   localparam int USABLE    = BANK_W - RSVD_BITS;

   logic in_range;
   logic usable_pos;

   assign bitpos     = id[BIT_W-1:0];
   assign in_range   = ({{(32-ID_W){1'b0}}, id} < 32'(TOTAL));
   assign usable_pos = ({{(32-BIT_W){1'b0}}, bitpos} < 32'(USABLE));
   assign valid      = in_range && usable_pos;  // R2

   // R1: bank index sits right above the bit position
   generate
      if (NUM_BANKS > 1) begin : g_multi
         assign bank = id[BIT_W +: SEL_W];
      end else begin : g_single
         assign bank = '0;
      end
   endgenerate

endmodule

// File: rtl/rail_dpd_watch.sv
`timescale 1ns/1ps
module rail_dpd_watch #(
   parameter int NUM_BANKS      = 2,
   parameter int BANK_W         = 32,
   parameter int TIMEOUT_CYCLES = 50_000_000,
   localparam int SEL_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int BIT_W         = $clog2(BANK_W),
   localparam int CNT_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] rail_status,
   input  logic [SEL_W-1:0]            bank,
   input  logic [BIT_W-1:0]            bitpos,
   input  logic                        target,
   input  logic                        clr,
   input  logic                        run,
   output logic                        hit,
   output logic                        expired
);
   logic [BANK_W-1:0] slice [NUM_BANKS];
   logic              sel_bit;
   logic [CNT_W-1:0]  cnt;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign slice[b] = rail_status[b*BANK_W +: BANK_W];
      end
   endgenerate

   // R4: only the selected rail of the selected bank is looked at
   assign sel_bit = slice[bank][bitpos];
   assign hit     = run && (sel_bit == target);
   assign expired = run && !hit && (cnt == CNT_W'(TIMEOUT_CYCLES - 1));

   // R8: count compare edges spent without a match
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (run && !hit && !expired) begin
         cnt <= cnt + 1'b1;
      end
   end

   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(TIMEOUT_CYCLES - 1));

   a_r8_clear_at_req: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/rail_dpd_seq.sv
`timescale 1ns/1ps
module rail_dpd_seq
   import rail_dpd_pkg::*;
#(
   parameter int NUM_BANKS     = 2,
   parameter int BANK_W        = 32,
   parameter int TIMER_W       = 16,
   parameter int CLK_PERIOD_PS = 5000,
   parameter int MIN_SETTLE_NS = 200,
   localparam int SEL_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int BIT_W        = $clog2(BANK_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_start,
   input  logic               cmd_off,
   input  logic               id_valid,
   input  logic [SEL_W-1:0]   id_bank,
   input  logic [BIT_W-1:0]   id_bit,
   input  logic               hit,
   input  logic               expired,
   output logic [SEL_W-1:0]   lat_bank,
   output logic [BIT_W-1:0]   lat_bit,
   output logic               lat_target,
   output logic               poll_clr,
   output logic               polling,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic               err_timeout,
   output logic               sample_en,
   output logic [TIMER_W-1:0] dpd_timer,
   output logic               req_wr,
   output logic [SEL_W-1:0]   req_bank,
   output logic [BANK_W-1:0]  req_word
);
   localparam int unsigned SETTLE = settle_cycles(CLK_PERIOD_PS, MIN_SETTLE_NS);
   localparam int unsigned P_NS   = period_ns(CLK_PERIOD_PS);

   seq_st_e           state;
   logic [BANK_W-1:0] word_n;

   assign busy     = (state != ST_IDLE);
   assign poll_clr = (state == ST_REQ);
   assign polling  = (state == ST_POLL);

   // R3: action code on top, one-hot rail bit below
   always_comb begin
      word_n                 = '0;
      word_n[BANK_W-1 -: 2]  = lat_target ? ACT_ENTER : ACT_LEAVE;
      word_n[lat_bit]        = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         lat_bank    <= '0;
         lat_bit     <= '0;
         lat_target  <= 1'b0;
         done        <= 1'b0;
         err         <= 1'b0;
         err_timeout <= 1'b0;
         sample_en   <= 1'b0;
         dpd_timer   <= '0;
         req_wr      <= 1'b0;
         req_bank    <= '0;
         req_word    <= '0;
      end else begin
         done   <= 1'b0;
         err    <= 1'b0;
         req_wr <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cmd_start) begin
                  if (id_valid) begin
                     lat_bank   <= id_bank;
                     lat_bit    <= id_bit;
                     lat_target <= cmd_off;
                     sample_en  <= 1'b1;      // R5 step 1
                     state      <= ST_ARM;
                  end else begin
                     err         <= 1'b1;     // R2
                     err_timeout <= 1'b0;
                  end
               end
            end
            ST_ARM: begin
               dpd_timer <= TIMER_W'(SETTLE); // R7
               state     <= ST_TIME;
            end
            ST_TIME: begin
               req_wr   <= 1'b1;               // R5 step 3
               req_bank <= lat_bank;
               req_word <= word_n;
               state    <= ST_REQ;
            end
            ST_REQ: begin
               state <= ST_POLL;
            end
            ST_POLL: begin
               if (hit) begin
                  done      <= 1'b1;           // R4
                  sample_en <= 1'b0;           // R6
                  state     <= ST_IDLE;
               end else if (expired) begin
                  err         <= 1'b1;         // R8
                  err_timeout <= 1'b1;
                  sample_en   <= 1'b0;         // R6
                  state       <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r5_req_under_sample: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |-> sample_en);

   a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |=> !req_wr);

   a_r6_end_drops_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !sample_en);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !err_timeout) |-> (!busy && !sample_en && !req_wr));

   a_r9_hold_command: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable({lat_bank, lat_bit, lat_target}));

   a_r7_timer_min: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |-> (32'(dpd_timer) * P_NS >= 32'(MIN_SETTLE_NS)));

endmodule

// File: rtl/rail_dpd_ctrl.sv
`timescale 1ns/1ps
module rail_dpd_ctrl #(
   parameter int NUM_BANKS      = 2,
   parameter int BANK_W         = 32,
   parameter int ID_W           = 7,
   parameter int TIMER_W        = 16,
   parameter int CLK_PERIOD_PS  = 5000,
   parameter int MIN_SETTLE_NS  = 200,
   parameter int TIMEOUT_CYCLES = 50_000_000,
   localparam int SEL_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int BIT_W         = $clog2(BANK_W)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_start,
   input  logic [ID_W-1:0]             cmd_rail,
   input  logic                        cmd_off,
   output logic                        busy,
   output logic                        done,
   output logic                        err,
   output logic                        err_timeout,
   output logic                        sample_en,
   output logic [TIMER_W-1:0]          dpd_timer,
   output logic                        req_wr,
   output logic [SEL_W-1:0]            req_bank,
   output logic [BANK_W-1:0]           req_word,
   input  logic [NUM_BANKS*BANK_W-1:0] rail_status
);
   localparam int RSVD_BITS = 2;

   initial begin
      assert (BANK_W >= 4 && (BANK_W & (BANK_W - 1)) == 0)
         else $error("BANK_W must be a power of two of at least 4");
      assert (ID_W >= BIT_W + SEL_W && ID_W < 32)
         else $error("ID_W too narrow for the rail space");
      assert (TIMEOUT_CYCLES >= 1)
         else $error("TIMEOUT_CYCLES must be positive");
      assert (rail_dpd_pkg::settle_cycles(CLK_PERIOD_PS, MIN_SETTLE_NS) < (1 << TIMER_W))
         else $error("TIMER_W cannot hold the settle count");
   end

   logic [SEL_W-1:0] id_bank, lat_bank;
   logic [BIT_W-1:0] id_bit, lat_bit;
   logic             id_valid, lat_target;
   logic             poll_clr, polling, hit, expired;

   rail_dpd_decode #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .ID_W      (ID_W),
      .RSVD_BITS (RSVD_BITS)
   ) u_decode (
      .id     (cmd_rail),
      .bank   (id_bank),
      .bitpos (id_bit),
      .valid  (id_valid)
   );

   rail_dpd_seq #(
      .NUM_BANKS     (NUM_BANKS),
      .BANK_W        (BANK_W),
      .TIMER_W       (TIMER_W),
      .CLK_PERIOD_PS (CLK_PERIOD_PS),
      .MIN_SETTLE_NS (MIN_SETTLE_NS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_off     (cmd_off),
      .id_valid    (id_valid),
      .id_bank     (id_bank),
      .id_bit      (id_bit),
      .hit         (hit),
      .expired     (expired),
      .lat_bank    (lat_bank),
      .lat_bit     (lat_bit),
      .lat_target  (lat_target),
      .poll_clr    (poll_clr),
      .polling     (polling),
      .busy        (busy),
      .done        (done),
      .err         (err),
      .err_timeout (err_timeout),
      .sample_en   (sample_en),
      .dpd_timer   (dpd_timer),
      .req_wr      (req_wr),
      .req_bank    (req_bank),
      .req_word    (req_word)
   );

   rail_dpd_watch #(
      .NUM_BANKS      (NUM_BANKS),
      .BANK_W         (BANK_W),
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .rail_status (rail_status),
      .bank        (lat_bank),
      .bitpos      (lat_bit),
      .target      (lat_target),
      .clr         (poll_clr),
      .run         (polling),
      .hit         (hit),
      .expired     (expired)
   );

   a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |-> (req_word[BANK_W-1 -: 2] inside {2'b01, 2'b10}));

   a_r3_one_rail: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |-> ($countones(req_word[BANK_W-RSVD_BITS-1:0]) == 1));

   a_r1_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |-> (32'(req_bank) < 32'(NUM_BANKS)));

   a_r6_busy_sample: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |-> busy);

endmodule

// File: tb/test_rail_dpd_ctrl.sv
`timescale 1ns/1ps
module test_rail_dpd_ctrl;
   localparam int CLK_PERIOD_NS = 6;
   localparam int T             = 40;
   localparam int EXP_TIMER     = (200 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [6:0]  cmd_rail = '0;
   logic        cmd_off = 1'b0;
   logic        busy, done, err, err_timeout, sample_en, req_wr;
   logic [15:0] dpd_timer;
   logic [0:0]  req_bank;
   logic [31:0] req_word;
   logic [63:0] rail_status = '0;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD_NS / 2) clk = ~clk;

   rail_dpd_ctrl #(
      .CLK_PERIOD_PS  (CLK_PERIOD_NS * 1000),
      .TIMEOUT_CYCLES (T)
   ) i_rail_dpd_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_rail    (cmd_rail),
      .cmd_off     (cmd_off),
      .busy        (busy),
      .done        (done),
      .err         (err),
      .err_timeout (err_timeout),
      .sample_en   (sample_en),
      .dpd_timer   (dpd_timer),
      .req_wr      (req_wr),
      .req_bank    (req_bank),
      .req_word    (req_word),
      .rail_status (rail_status)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit usable(input int id);
      return (id < 64) && ((id % 32) < 30);
   endfunction

   function automatic logic [31:0] exp_word(input int id, input bit off);
      return ((off ? 32'h2 : 32'h1) << 30) | (32'h1 << (id % 32));
   endfunction

   task automatic run_reject(input int id);
      @(negedge clk);
      cmd_rail = 7'(id); cmd_off = id[0]; cmd_start = 1'b1;
      @(posedge clk); @(negedge clk);
      cmd_start = 1'b0;
      chk(err == 1'b1 && err_timeout == 1'b0, "R2 refuse flags", {err, err_timeout}, 2'b10);
      chk(!busy && !sample_en && !req_wr, "R2 no activity", {busy, sample_en, req_wr}, 0);
      @(posedge clk); @(negedge clk);
      chk(!err && !sample_en && !req_wr && !busy, "R10 R2 refuse pulse ends",
          {err, sample_en, req_wr, busy}, 0);
   endtask

   task automatic run_cmd(input int id, input bit off, input int k, input bit poke);
      int n, cnt, exp_n, other;
      bit pend, already, exp_to, fin;
      logic [63:0] noise;
      @(negedge clk);
      rail_status = {$urandom, $urandom};
      already = (rail_status[id] == off);
      if (already) begin exp_n = 4; exp_to = 1'b0; end
      else if (k <= T) begin exp_n = (3 + k > 4) ? 3 + k : 4; exp_to = 1'b0; end
      else begin exp_n = 3 + T; exp_to = 1'b1; end
      cmd_rail = 7'(id); cmd_off = off; cmd_start = 1'b1;
      @(posedge clk); @(negedge clk);
      cmd_start = 1'b0;
      n = 0; cnt = 0; pend = 1'b0; fin = 1'b0;
      while (!fin) begin
         case (n)
            0: begin
               chk(sample_en == 1'b1, "R5 sample_en first", sample_en, 1);
               chk(busy == 1'b1, "R9 busy after start", busy, 1);
            end
            1: begin
               chk(dpd_timer == 16'(EXP_TIMER), "R7 settle count", dpd_timer, EXP_TIMER);
               chk(req_wr == 1'b0, "R5 no early request", req_wr, 0);
               if (poke) begin
                  other = (id + 7) % 30;
                  cmd_rail = 7'(other); cmd_off = ~off; cmd_start = 1'b1;
               end
            end
            2: begin
               cmd_start = 1'b0;
               chk(req_wr == 1'b1, "R5 request strobe", req_wr, 1);
               chk(req_bank == 1'(id / 32), "R1 bank select", req_bank, id / 32);
               chk(req_word == exp_word(id, off), "R1 R3 request word", req_word, exp_word(id, off));
            end
            3: chk(req_wr == 1'b0, "R5 single strobe", req_wr, 0);
            default: ;
         endcase
         if (done || err) begin
            fin = 1'b1;
            chk(n == exp_n, exp_to ? "R8 timeout cycle" : "R4 completion cycle", n, exp_n);
            chk(done == !exp_to && err == exp_to, "R4 R8 outcome", {done, err}, {!exp_to, exp_to});
            chk(err_timeout == exp_to || !err, "R8 timeout flag", err_timeout, exp_to);
            chk(sample_en == 1'b0, "R6 sample off at end", sample_en, 0);
            chk(busy == 1'b0, "R9 busy ends", busy, 0);
         end else if (n > 3 + T + 5) begin
            fin = 1'b1;
            chk(1'b0, "R4 no completion", n, exp_n);
         end
         // rail model: commanded bit follows k cycles after the strobe
         if (req_wr) begin
            if (k == 0) rail_status[id] = off;
            else begin pend = 1'b1; cnt = k; end
         end else if (pend) begin
            cnt--;
            if (cnt == 0) begin rail_status[id] = off; pend = 1'b0; end
         end
         noise = {$urandom, $urandom};
         noise[id] = 1'b0;
         rail_status = rail_status ^ noise;
         if (!fin) begin
            @(posedge clk); @(negedge clk);
            n++;
         end
      end
      @(posedge clk); @(negedge clk);
      chk(!done && !err, "R10 single pulse", {done, err}, 0);
      chk(!sample_en && !busy, "R9 start while busy ignored", {sample_en, busy}, 0);
   endtask

   initial begin
      #(CLK_PERIOD_NS * 200000);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err && !sample_en && !req_wr, "R9 reset idle",
          {busy, done, err, sample_en, req_wr}, 0);
      chk(dpd_timer == '0, "R7 reset timer", dpd_timer, 0);

      // R2 refused ids, including both reserved positions of each bank
      run_reject(30); run_reject(31); run_reject(62); run_reject(63);
      run_reject(64); run_reject(127);

      // directed corners: bank edges, k boundaries, start while busy
      run_cmd(0,  1'b0, 0,     1'b0);
      run_cmd(29, 1'b1, 3,     1'b1);
      run_cmd(32, 1'b0, T,     1'b0);   // R8 match on last compare edge
      run_cmd(61, 1'b1, T + 1, 1'b0);   // R8 one cycle too late
      run_cmd(33, 1'b1, 1,     1'b1);
      run_reject(30);                    // R2 after a timeout clears flag

      for (int i = 0; i < 160; i++) begin
         int id;
         if (($urandom % 4) != 0) id = (($urandom % 2) * 32) + ($urandom % 30);
         else id = $urandom % 128;
         if (usable(id)) run_cmd(id, 1'($urandom % 2), $urandom % (T + 6), 1'($urandom % 2));
         else run_reject(id);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule